// File: doc/BRIEF.md
# Two-Stage Output Virtual-Channel Allocator

This block hands out output virtual channels to packets waiting at the input virtual channels of a five-port router with two virtual channels per port. Route computation gives each packet only its output port. The allocator therefore picks the output virtual channel. Each input VC presents its request, a head-flit flag, a message class and the output port. A registered grant comes back, together with the VC index chosen at that port.

Stage one looks at one input VC at a time. It chooses, among the output VCs at the requested port, one that is free and whose class fits the packet. Control packets may only use VC 0 and data packets may only use VC 1. Stage two holds one round-robin arbiter for each output VC. Each arbiter picks a single winner among the input VCs that aimed at that output VC.

The block keeps an owner table. It records which output VC each input VC holds. When the input VC signals that its tail flit has left, the block frees that output VC. Allocation happens once per packet, on the head flit.

Top module: `vc_alloc_2stage`

## Requirements
- R1: Asynchronous reset (rst_n low) clears all grants, frees every output VC, empties the owner table and sets every round-robin pointer to 0. A VC held before reset can be granted again after it.
- R2: The class bit is 0 for control and 1 for data. A granted control packet receives VC 0 and a granted data packet receives VC 1 at its port. For input VC i, that index is gnt_vc[i].
- R3: Only free output VCs are granted. A granted output VC stays busy until the input VC that holds it pulses in_tail_go. Requests sampled in the same cycle as that pulse still see the VC busy, and requests in the following cycle see it free.
- R4: A grant is registered. Inputs sampled at one rising edge produce gnt and gnt_vc right after that edge. A grant lasts one cycle, even when the request is held.
- R5: At most one input VC wins an output VC in a cycle. Each output VC's arbiter searches upward from its pointer, wrapping around. After a grant the pointer moves to winner+1. Input VC i and output VC o are numbered port*2+vc.
- R6: An input VC that loses arbitration, or finds its target busy, keeps its request and is granted in a later cycle once it wins.
- R7: A request counts only while in_head is 1. An input VC that already holds an output VC makes no new request until its tail has departed.
- R8: Requests aimed at different output VCs are granted in the same cycle, independently of each other.
- R9: A request whose port field is 5, 6 or 7 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 10 | Request, one bit per input VC (port*2+vc) |
| in_head | input | 10 | The waiting flit is a head flit |
| in_cls | input | 10 | Message class: 0 control, 1 data |
| in_port | input | 30 | Output port, 3 bits per input VC, input VC i at bits [3i+2:3i] |
| in_tail_go | input | 10 | Pulse: the tail flit of input VC i has left, so its output VC is freed |
| gnt | output | 10 | One-cycle grant, one bit per input VC |
| gnt_vc | output | 10 | Output VC index assigned to input VC i, valid while gnt[i] is high |

## Verification
Every grant is due one rising edge after the request is sampled. A freed output VC can be granted to a request sampled one edge after the tail pulse, and the grant appears one edge later still. The bench changes inputs on the falling edge and reads gnt and gnt_vc on the next falling edge, so each check sits exactly one register stage after its stimulus. Cases that depend on state, such as a busy VC that must stay refused, a release and the rotation of the round-robin pointer, are laid out as consecutive steps. The expected result of each step follows from the state left by the steps before it.

// File: rtl/vca_pkg.sv
package vca_pkg;
  localparam int NUM_PORTS = 5;
  localparam int NUM_VCS   = 2;

  typedef enum logic {
    CLS_CTRL = 1'b0,
    CLS_DATA = 1'b1
  } msg_cls_e;
endpackage

// File: rtl/vca_pick.sv
// Stage one: fixed lowest-index choice among the candidate output VCs of one port.
module vca_pick #(
  parameter int V  = 2,
  parameter int VW = 1
) (
  input  logic [V-1:0]  cand,
  output logic          vld,
  output logic [VW-1:0] sel
);
  always_comb begin
    vld = |cand;
    sel = '0;
    for (int v = V - 1; v >= 0; v--) begin
      if (cand[v]) sel = VW'(v);
    end
  end
endmodule

// File: rtl/vca_rr.sv
// Stage two: round-robin arbiter for one output VC.
module vca_rr #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  localparam int NW = (N > 1) ? $clog2(N) : 1;

  logic [NW-1:0] ptr_q, ptr_d, win;
  logic [NW:0]   sum;

  always_comb begin
    gnt = '0;
    any = 1'b0;
    win = '0;
    sum = '0;
    for (int k = 0; k < N; k++) begin
      sum = {1'b0, ptr_q} + (NW+1)'(k);
      if (sum >= (NW+1)'(N)) sum = sum - (NW+1)'(N);
      if (!any && req[sum[NW-1:0]]) begin
        any = 1'b1;
        win = sum[NW-1:0];
      end
    end
    if (any) gnt[win] = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (any) ptr_d = (win == NW'(N - 1)) ? '0 : win + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R5: a single winner per output VC per cycle
  a_r5_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/vc_alloc_2stage.sv
module vc_alloc_2stage #(
  parameter int P = vca_pkg::NUM_PORTS,
  parameter int V = vca_pkg::NUM_VCS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [P*V-1:0]              in_req,
  input  logic [P*V-1:0]              in_head,
  input  logic [P*V-1:0]              in_cls,
  input  logic [P*V*$clog2(P)-1:0]    in_port,
  input  logic [P*V-1:0]              in_tail_go,
  output logic [P*V-1:0]              gnt,
  output logic [P*V*((V>1)?$clog2(V):1)-1:0] gnt_vc
);
  import vca_pkg::*;

  localparam int PV   = P * V;
  localparam int PW   = $clog2(P);
  localparam int VW   = (V > 1) ? $clog2(V) : 1;
  localparam int OW   = $clog2(PV);
  localparam int HALF = V / 2;

  function automatic logic [OW-1:0] ovc_of(logic [PW-1:0] p, logic [VW-1:0] v);
    return OW'(p) * OW'(V) + OW'(v);
  endfunction

  // state
  logic [PV-1:0] busy_q, busy_d;
  logic [PV-1:0] held_q, held_d;
  logic [OW-1:0] hovc_q [PV];
  logic [OW-1:0] hovc_d [PV];
  logic [PV-1:0] gnt_q, gnt_d;
  logic [VW-1:0] gvc_q [PV];
  logic [VW-1:0] gvc_d [PV];

  // stage one results
  logic [PV-1:0] c_vld;
  logic [VW-1:0] c_vc  [PV];
  logic [OW-1:0] c_ovc [PV];

  genvar gi, go;
  generate
    for (gi = 0; gi < PV; gi++) begin : g_in
      logic [PW-1:0] port_raw, port_sel;
      logic          port_ok, live;
      logic [V-1:0]  cand;

      assign port_raw = in_port[gi*PW +: PW];
      assign port_ok  = (port_raw < PW'(P));
      assign port_sel = port_ok ? port_raw : '0;
      assign live     = in_req[gi] & in_head[gi] & ~held_q[gi] & port_ok;

      always_comb begin
        for (int v = 0; v < V; v++) begin
          cand[v] = live
                 && ((v >= HALF) == (msg_cls_e'(in_cls[gi]) == CLS_DATA))
                 && !busy_q[ovc_of(port_sel, VW'(v))];
        end
      end

      vca_pick #(.V(V), .VW(VW)) u_pick (
        .cand (cand),
        .vld  (c_vld[gi]),
        .sel  (c_vc[gi])
      );

      assign c_ovc[gi] = ovc_of(port_sel, c_vc[gi]);
      assign gnt_vc[gi*VW +: VW] = gvc_q[gi];

      // R2: assigned VC lies in the class range of the request
      a_r2_class: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_q[gi] |-> ((gvc_q[gi] >= VW'(HALF)) == $past(in_cls[gi])));
      // R4: grant is a single-cycle pulse
      a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_q[gi] |=> !gnt_q[gi]);
      // R7: holder does not compete again
      a_r7_holder_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        held_q[gi] |-> !c_vld[gi]);
    end
  endgenerate

  // stage two
  logic [PV-1:0] r2  [PV];
  logic [PV-1:0] s2g [PV];
  logic [PV-1:0] s2any;
  logic [PV-1:0] win;

  generate
    for (go = 0; go < PV; go++) begin : g_out
      always_comb begin
        for (int i = 0; i < PV; i++) r2[go][i] = c_vld[i] && (c_ovc[i] == OW'(go));
      end

      vca_rr #(.N(PV)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (r2[go]),
        .gnt   (s2g[go]),
        .any   (s2any[go])
      );

      // R3: only a free output VC is handed out
      a_r3_free_only: assert property (@(posedge clk) disable iff (!rst_n)
        s2any[go] |-> !busy_q[go]);
      // R3: an output VC turns busy only through a grant
      a_r3_busy_by_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q[go]) |-> $past(s2any[go]));
    end
  endgenerate

  always_comb begin
    win = '0;
    for (int o = 0; o < PV; o++) win = win | s2g[o];
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    held_d = held_q;
    gnt_d  = '0;
    for (int i = 0; i < PV; i++) begin
      hovc_d[i] = hovc_q[i];
      gvc_d[i]  = gvc_q[i];
    end
    for (int i = 0; i < PV; i++) begin
      if (in_tail_go[i] && held_q[i]) begin
        held_d[i]         = 1'b0;
        busy_d[hovc_q[i]] = 1'b0;
      end
    end
    for (int i = 0; i < PV; i++) begin
      if (win[i]) begin
        gnt_d[i]         = 1'b1;
        gvc_d[i]         = c_vc[i];
        held_d[i]        = 1'b1;
        hovc_d[i]        = c_ovc[i];
        busy_d[c_ovc[i]] = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      held_q <= '0;
      gnt_q  <= '0;
      for (int i = 0; i < PV; i++) begin
        hovc_q[i] <= '0;
        gvc_q[i]  <= '0;
      end
    end else begin
      busy_q <= busy_d;
      held_q <= held_d;
      gnt_q  <= gnt_d;
      for (int i = 0; i < PV; i++) begin
        hovc_q[i] <= hovc_d[i];
        gvc_q[i]  <= gvc_d[i];
      end
    end
  end

  assign gnt = gnt_q;
endmodule

// File: tb/sim_vc_alloc_2stage.sv
`timescale 1ns/1ps
module sim_vc_alloc_2stage;
  localparam int P  = 5;
  localparam int V  = 2;
  localparam int PV = P * V;

  logic          clk, rst_n;
  logic [PV-1:0] in_req, in_head, in_cls, in_tail_go;
  logic [PV*3-1:0] in_port;
  logic [PV-1:0] gnt;
  logic [PV-1:0] gnt_vc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vc_alloc_2stage u0 (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_head(in_head),
    .in_cls(in_cls), .in_port(in_port), .in_tail_go(in_tail_go),
    .gnt(gnt), .gnt_vc(gnt_vc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {req, head, cls, tail, dst(3), expected gnt}
  localparam logic [52:0] STEPS [0:16] = '{
    {10'h000, 10'h000, 10'h000, 10'h000, 3'd0, 10'h000},  // R1 idle
    {10'h001, 10'h001, 10'h000, 10'h000, 3'd2, 10'h001},  // R2 control gets VC0
    {10'h006, 10'h006, 10'h004, 10'h000, 3'd2, 10'h004},  // R3 busy VC0, R8 data VC1
    {10'h002, 10'h002, 10'h000, 10'h001, 3'd2, 10'h000},  // R3 release not yet visible
    {10'h002, 10'h002, 10'h000, 10'h000, 3'd2, 10'h002},  // R6 retry granted
    {10'h000, 10'h000, 10'h000, 10'h006, 3'd2, 10'h000},
    {10'h00B, 10'h00B, 10'h000, 10'h000, 3'd2, 10'h008},  // R5 pointer at 2 -> 3
    {10'h003, 10'h003, 10'h000, 10'h008, 3'd2, 10'h000},
    {10'h003, 10'h003, 10'h000, 10'h000, 3'd2, 10'h001},  // R5 wrap to 0
    {10'h002, 10'h002, 10'h000, 10'h001, 3'd2, 10'h000},
    {10'h002, 10'h002, 10'h000, 10'h000, 3'd2, 10'h002},  // R6 loser retried
    {10'h010, 10'h000, 10'h010, 10'h002, 3'd0, 10'h000},  // R7 body flit ignored
    {10'h010, 10'h010, 10'h010, 10'h000, 3'd0, 10'h010},
    {10'h010, 10'h010, 10'h000, 10'h000, 3'd3, 10'h000},  // R7 holder blocked
    {10'h000, 10'h000, 10'h000, 10'h010, 3'd0, 10'h000},
    {10'h0E0, 10'h0E0, 10'h0C0, 10'h000, 3'd4, 10'h060},  // R5 R8 two output VCs
    {10'h000, 10'h000, 10'h000, 10'h060, 3'd4, 10'h000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [PV-1:0] rq, input logic [PV-1:0] hd,
                       input logic [PV-1:0] cl, input logic [PV-1:0] tl,
                       input logic [PV*3-1:0] pt);
    in_req = rq; in_head = hd; in_cls = cl; in_tail_go = tl; in_port = pt;
  endtask

  function automatic logic [PV*3-1:0] all_to(input logic [2:0] d);
    logic [PV*3-1:0] r;
    for (int i = 0; i < PV; i++) r[i*3 +: 3] = d;
    return r;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [PV*3-1:0] pv;
    rst_n = 1'b0;
    drive('0, '0, '0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset grants", 32'(gnt), 32'h0);

    // table walk
    for (int s = 0; s < 17; s++) begin
      drive(STEPS[s][52:43], STEPS[s][42:33], STEPS[s][32:23], STEPS[s][22:13],
            all_to(STEPS[s][12:10]));
      @(negedge clk);
      chk($sformatf("R3/R5 step %0d gnt", s), 32'(gnt), 32'(STEPS[s][9:0]));
      for (int i = 0; i < PV; i++) begin
        if (STEPS[s][i])
          chk($sformatf("R2 step %0d vc of input %0d", s, i), 32'(gnt_vc[i]),
              32'(STEPS[s][23+i]));
      end
    end

    // R8: two ports in parallel, then R4 pulse with request held
    pv = '0; pv[0*3 +: 3] = 3'd1; pv[2*3 +: 3] = 3'd3;
    drive(10'h005, 10'h005, 10'h004, '0, pv);
    @(negedge clk);
    chk("R8 parallel gnt", 32'(gnt), 32'h005);
    chk("R2 parallel vc input0", 32'(gnt_vc[0]), 32'h0);
    chk("R2 parallel vc input2", 32'(gnt_vc[2]), 32'h1);
    @(negedge clk);
    chk("R4 single pulse", 32'(gnt), 32'h0);
    drive('0, '0, '0, 10'h005, pv);
    @(negedge clk);

    // R9: port out of range
    pv = '0; pv[3*3 +: 3] = 3'd6;
    drive(10'h008, 10'h008, 10'h000, '0, pv);
    @(negedge clk);
    chk("R9 port 6 ignored", 32'(gnt), 32'h0);
    pv[3*3 +: 3] = 3'd7;
    drive(10'h008, 10'h008, 10'h000, '0, pv);
    @(negedge clk);
    chk("R9 port 7 ignored", 32'(gnt), 32'h0);

    // R1: reset frees a held VC
    pv = '0; pv[0*3 +: 3] = 3'd1; pv[1*3 +: 3] = 3'd1;
    drive(10'h001, 10'h001, '0, '0, pv);
    @(negedge clk);
    chk("R1 pre-reset grant", 32'(gnt), 32'h001);
    drive('0, '0, '0, '0, pv);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 grants cleared", 32'(gnt), 32'h0);
    drive(10'h002, 10'h002, '0, '0, pv);
    @(negedge clk);
    chk("R1 VC free after reset", 32'(gnt), 32'h002);

    done = 1;
    summary();
    $finish;
  end
endmodule